// File: doc/BRIEF.md
# Region Read-Modify-Write Store Controller

This controller sits between a processor's single-word load/store port and a non-volatile main memory. That memory can only be written one aligned region at a time. A load becomes a single one-word memory read and takes one read latency. A store becomes a three-phase sequence:

- every word of the 128-word region holding the target address is fetched, one read at a time, into an on-chip region buffer;
- the store data is merged into the buffer at the word's offset;
- the whole buffer is streamed out and committed as one region write.

The processor sees a ready signal that falls when a request is accepted and rises again when the operation ends. A one-cycle response pulse marks the end of every operation.

Memory timing is set by two cycle-count parameters: `RD_LAT` for one word read and `WB_CYC` for a region commit. The memory also reports the end of a commit with a done pulse. The controller leaves the commit phase only when both the `WB_CYC` count has run out and the done pulse has been seen.

Top module: `rgn_rmw_ctrl`

## Requirements
- R1: After reset, ready is 1, and mem_rd_en, wb_valid, wb_commit and rsp_valid are all 0.
- R2: A request with req_we=0, accepted while ready is 1, produces exactly one read. That read holds mem_rd_en high for RD_LAT cycles with mem_addr equal to req_addr. It is followed by a one-cycle rsp_valid carrying the word read, and it causes no wb_valid or wb_commit activity.
- R3: A request with req_we=1 first performs 128 reads. Their addresses run from base to base+127 in ascending order, where base is req_addr with bits [6:0] cleared, and each read holds mem_rd_en for RD_LAT cycles.
- R4: After the reads, a store emits 128 wb_valid beats with wb_idx running from 0 to 127 in order. Each wb_data equals the word fetched at that offset, except at offset req_addr[6:0], which carries req_wdata.
- R5: After the last beat, wb_commit stays high with wb_addr equal to the region base. It falls after the cycle in which both WB_CYC commit cycles have elapsed and mem_wb_done has been seen. A done pulse in commit cycle k therefore gives max(WB_CYC, k) commit cycles.
- R6: A store ends with a one-cycle rsp_valid in the cycle after wb_commit falls, and ready is 1 in that cycle.
- R7: ready is 0 from the cycle after acceptance until the response. Requests presented while ready is 0 cause no extra reads and no extra responses.
- R8: Stores at offsets 0 and 127, and at the first word of the next region, merge at the right word and leave neighbouring regions unchanged; later loads return the merged values.
- R9: A done pulse that arrives before the WB_CYC count runs out is remembered until the count runs out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor request strobe |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| ready | output | 1 | Controller idle and able to accept a request |
| rsp_valid | output | 1 | One-cycle end-of-operation pulse |
| rsp_data | output | DW | Load result |
| mem_rd_en | output | 1 | Word read in progress |
| mem_addr | output | AW | Word read address |
| mem_rd_data | input | DW | Word read data, sampled in the last read cycle |
| wb_valid | output | 1 | Region stream beat valid |
| wb_idx | output | 7 | Offset of the streamed word |
| wb_data | output | DW | Streamed buffer word |
| wb_addr | output | AW | Region base for the commit |
| wb_commit | output | 1 | Region commit in progress |
| mem_wb_done | input | 1 | Memory pulse marking the end of the commit |

## Verification
Two events can land in the same cycle: the memory's done pulse and the expiry of the commit count. The bench makes them coincide by raising mem_wb_done in commit cycle WB_CYC exactly, and it also places the pulse well before and well after that cycle. It judges each case by counting the wb_commit cycles against max(WB_CYC, k) and by checking that the response follows in the next cycle. In the same way, a stream of requests arriving during a busy store is judged by the read trace and the response count staying unchanged.

// File: rtl/rgn_rmw_pkg.sv
package rgn_rmw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FILL,
    ST_MERGE,
    ST_STREAM,
    ST_COMMIT
  } rmw_state_e;
endpackage

// File: rtl/rgn_lat_timer.sv
module rgn_lat_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len_m1,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= len_m1;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rgn_buf.sv
module rgn_buf #(
  parameter int DW    = 16,
  parameter int DEPTH = 128,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rgn_rmw_ctrl.sv
module rgn_rmw_ctrl
  import rgn_rmw_pkg::*;
#(
  parameter int DW        = 16,
  parameter int AW        = 16,
  parameter int RGN_WORDS = 128,
  parameter int RD_LAT    = 1,
  parameter int WB_CYC    = 512,
  localparam int OW       = $clog2(RGN_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rd_data,
  output logic          wb_valid,
  output logic [OW-1:0] wb_idx,
  output logic [DW-1:0] wb_data,
  output logic [AW-1:0] wb_addr,
  output logic          wb_commit,
  input  logic          mem_wb_done
);
  localparam int MAXC = (RD_LAT > WB_CYC) ? RD_LAT : WB_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] RD_M1 = CW'(RD_LAT - 1);
  localparam logic [CW-1:0] WB_M1 = CW'(WB_CYC - 1);
  localparam logic [OW-1:0] LAST  = OW'(RGN_WORDS - 1);
  localparam logic [AW-1:0] OFF_MASK = AW'(RGN_WORDS - 1);

  rmw_state_e    state;
  logic [OW-1:0] idx;
  logic [OW-1:0] off_q;
  logic [DW-1:0] wdata_q;
  logic [AW-1:0] base_q;
  logic          done_seen;

  logic          accept;
  logic          tmr_load;
  logic [CW-1:0] tmr_len;
  logic          tmr_exp;
  logic          commit_end;

  logic          buf_we;
  logic [OW-1:0] buf_waddr;
  logic [DW-1:0] buf_wdata;

  assign accept     = ready && req_valid;
  assign commit_end = (state == ST_COMMIT) && tmr_exp && (done_seen || mem_wb_done);
  assign tmr_load   = accept
                    || ((state == ST_FILL) && tmr_exp && (idx != LAST))
                    || ((state == ST_STREAM) && (idx == LAST));
  assign tmr_len    = (state == ST_STREAM) ? WB_M1 : RD_M1;

  assign buf_we    = ((state == ST_FILL) && tmr_exp) || (state == ST_MERGE);
  assign buf_waddr = (state == ST_MERGE) ? off_q : idx;
  assign buf_wdata = (state == ST_MERGE) ? wdata_q : mem_rd_data;
  assign wb_addr   = base_q;

  rgn_lat_timer #(.CW(CW)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .len_m1  (tmr_len),
    .expired (tmr_exp)
  );

  rgn_buf #(.DW(DW), .DEPTH(RGN_WORDS), .IW(OW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .raddr (idx),
    .rdata (wb_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ready     <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      wb_valid  <= 1'b0;
      wb_idx    <= '0;
      wb_commit <= 1'b0;
      base_q    <= '0;
      off_q     <= '0;
      wdata_q   <= '0;
      idx       <= '0;
      done_seen <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      wb_valid  <= (state == ST_STREAM);
      wb_idx    <= idx;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ready     <= 1'b0;
            mem_rd_en <= 1'b1;
            idx       <= '0;
            if (req_we) begin
              base_q   <= req_addr & ~OFF_MASK;
              mem_addr <= req_addr & ~OFF_MASK;
              off_q    <= req_addr[OW-1:0];
              wdata_q  <= req_wdata;
              state    <= ST_FILL;
            end else begin
              mem_addr <= req_addr;
              state    <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          if (tmr_exp) begin
            rsp_data  <= mem_rd_data;
            rsp_valid <= 1'b1;
            mem_rd_en <= 1'b0;
            ready     <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        ST_FILL: begin
          if (tmr_exp) begin
            if (idx == LAST) begin
              mem_rd_en <= 1'b0;
              idx       <= '0;
              state     <= ST_MERGE;
            end else begin
              idx      <= idx + OW'(1);
              mem_addr <= mem_addr + AW'(1);
            end
          end
        end
        ST_MERGE: state <= ST_STREAM;
        ST_STREAM: begin
          if (idx == LAST) begin
            wb_commit <= 1'b1;
            done_seen <= 1'b0;
            state     <= ST_COMMIT;
          end else begin
            idx <= idx + OW'(1);
          end
        end
        ST_COMMIT: begin
          if (mem_wb_done) done_seen <= 1'b1;
          if (commit_end) begin
            wb_commit <= 1'b0;
            done_seen <= 1'b0;
            ready     <= 1'b1;
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rgn_rmw_chk.sv
module rgn_rmw_chk #(
  parameter int AW = 16,
  parameter int OW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          ready,
  input logic          rsp_valid,
  input logic          mem_rd_en,
  input logic          wb_valid,
  input logic [OW-1:0] wb_idx,
  input logic [AW-1:0] wb_addr,
  input logic          wb_commit
);
  // R1: idle outputs right after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ready && !mem_rd_en && !wb_valid && !wb_commit && !rsp_valid));

  // R7: nothing moves while the controller offers ready
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!mem_rd_en && !wb_valid && !wb_commit));

  // R3: region reads never overlap the commit
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && wb_commit));

  // R4: commit starts together with the last stream beat
  p_last_beat_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_commit) |-> (wb_valid && (wb_idx == OW'((1 << OW) - 1))));

  // R5: commit address is region aligned and held
  p_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    wb_commit |-> (wb_addr[OW-1:0] == '0));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wb_commit && $past(wb_commit)) |-> $stable(wb_addr));

  // R6: response is a single cycle and coincides with ready
  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_rsp_ready_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ready);
endmodule

bind rgn_rmw_ctrl rgn_rmw_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ready     (ready),
  .rsp_valid (rsp_valid),
  .mem_rd_en (mem_rd_en),
  .wb_valid  (wb_valid),
  .wb_idx    (wb_idx),
  .wb_addr   (wb_addr),
  .wb_commit (wb_commit)
);

// File: tb/tb_rgn_rmw_ctrl.sv
module tb_rgn_rmw_ctrl;
  localparam int RD = 2;
  localparam int WB = 20;

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0, req_we = 0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic ready, rsp_valid, mem_rd_en, wb_valid, wb_commit;
  logic mem_wb_done = 0;
  logic [15:0] rsp_data, mem_addr, mem_rd_data, wb_data, wb_addr;
  logic [6:0] wb_idx;

  always #4 clk = ~clk;

  rgn_rmw_ctrl #(.DW(16), .AW(16), .RGN_WORDS(128), .RD_LAT(RD), .WB_CYC(WB)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .wb_valid(wb_valid),
    .wb_idx(wb_idx), .wb_data(wb_data), .wb_addr(wb_addr),
    .wb_commit(wb_commit), .mem_wb_done(mem_wb_done)
  );

  logic [15:0] mem [512];
  logic [15:0] shadow [512];
  logic [15:0] wbuf [128];
  assign mem_rd_data = mem[mem_addr[8:0]];

  int checks = 0, fails = 0;
  int rd_cyc, rd_bad, wb_cnt, wb_bad, commit_cnt, rsp_cnt, done_k;
  logic [15:0] mon_base, wb_seen, rsp_d;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_rd_en) begin
      if (mem_addr != mon_base + 16'(rd_cyc / RD)) rd_bad++;
      rd_cyc++;
    end
    if (wb_valid) begin
      if (int'(wb_idx) != wb_cnt) wb_bad++;
      wbuf[wb_idx] = wb_data;
      wb_cnt++;
    end
    if (wb_commit) begin
      commit_cnt++;
      wb_seen = wb_addr;
      mem_wb_done = (commit_cnt == done_k);
    end else mem_wb_done = 1'b0;
    if (rsp_valid) begin
      rsp_cnt++;
      rsp_d = rsp_data;
    end
  end

  task automatic run(input bit st, input logic [15:0] a, input logic [15:0] d,
                     input int k, input bit spam);
    int n;
    int mism;
    int rc;
    logic [15:0] base;
    @(negedge clk); #1;
    while (!ready) begin @(negedge clk); #1; end
    rd_cyc = 0; rd_bad = 0; wb_cnt = 0; wb_bad = 0; commit_cnt = 0; rsp_cnt = 0;
    done_k = k;
    base = st ? (a & 16'hFF80) : a;
    mon_base = base;
    req_valid = 1; req_we = st; req_addr = a; req_wdata = d;
    @(negedge clk); #1;
    req_valid = 0;
    chk(ready == 0, "R7 ready low after accept", ready, 0);
    n = 0;
    while (rsp_cnt == 0 && n < 4000) begin
      if (spam) begin
        req_valid = (n >= 10 && n < 15);
        req_we = 0; req_addr = 16'h0033;
      end
      @(negedge clk); #1;
      n++;
    end
    req_valid = 0;
    chk(rsp_cnt == 1 && ready == 1, "R6 response with ready", rsp_cnt, 1);
    chk(rd_bad == 0, st ? "R3 fill read addresses" : "R2 load read address", rd_bad, 0);
    if (!st) begin
      chk(rd_cyc == RD, "R2 load read cycles", rd_cyc, RD);
      chk(rsp_d == shadow[a[8:0]], "R2 load data", rsp_d, shadow[a[8:0]]);
      chk(wb_cnt == 0 && commit_cnt == 0, "R2 no write activity", wb_cnt + commit_cnt, 0);
    end else begin
      chk(rd_cyc == 128 * RD, "R3 fill read cycles", rd_cyc, 128 * RD);
      chk(wb_cnt == 128 && wb_bad == 0, "R4 stream beats in order", wb_cnt, 128);
      mism = 0;
      for (int i = 0; i < 128; i++) begin
        if (wbuf[i] != ((i == int'(a[6:0])) ? d : shadow[base[8:0] + 9'(i)])) mism++;
      end
      chk(mism == 0, "R4 R8 merged region contents", mism, 0);
      chk(wb_seen == base, "R5 commit base address", wb_seen, base);
      chk(commit_cnt == ((k > WB) ? k : WB), "R5 R9 commit length", commit_cnt,
          (k > WB) ? k : WB);
      for (int i = 0; i < 128; i++) mem[base[8:0] + 9'(i)] = wbuf[i];
      shadow[a[8:0]] = d;
    end
    if (spam) begin
      rc = rd_cyc;
      repeat (10) @(negedge clk);
      #1;
      chk(rsp_cnt == 1 && rd_cyc == rc, "R7 busy requests ignored", rsp_cnt, 1);
    end
  endtask

  // {store, addr, data, done cycle}
  localparam logic [48:0] VEC [11] = '{
    {1'b1, 16'h0005, 16'hA5A5, 16'd3},
    {1'b0, 16'h0005, 16'h0000, 16'd0},
    {1'b1, 16'h007F, 16'h1234, 16'd20},
    {1'b1, 16'h0080, 16'hBEEF, 16'd30},
    {1'b0, 16'h007F, 16'h0000, 16'd0},
    {1'b0, 16'h0080, 16'h0000, 16'd0},
    {1'b0, 16'h0081, 16'h0000, 16'd0},
    {1'b0, 16'h007E, 16'h0000, 16'd0},
    {1'b1, 16'h0100, 16'h0F0F, 16'd1},
    {1'b0, 16'h0100, 16'h0000, 16'd0},
    {1'b0, 16'h01FF, 16'h0000, 16'd0}
  };

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = 16'h1000 + 16'(i * 3);
      shadow[i] = 16'h1000 + 16'(i * 3);
    end
    done_k = 0; rd_cyc = 0; rd_bad = 0; wb_cnt = 0; wb_bad = 0;
    commit_cnt = 0; rsp_cnt = 0; mon_base = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk); #1;
    chk(ready == 1 && !mem_rd_en && !wb_valid && !wb_commit && !rsp_valid,
        "R1 reset state", {ready, mem_rd_en, wb_valid, wb_commit, rsp_valid}, 5'b10000);
    repeat (5) @(negedge clk);
    #1;
    chk(rd_cyc == 0 && ready == 1, "R1 no access before request", rd_cyc, 0);

    for (int v = 0; v < 11; v++)
      run(VEC[v][48], VEC[v][47:32], VEC[v][31:16], int'(VEC[v][15:0]), 1'b0);

    // R7: requests during a busy store; R9: done pulse at the expiry cycle
    run(1'b1, 16'h01C3, 16'h5A5A, WB, 1'b1);
    run(1'b0, 16'h01C3, 16'h0000, 0, 1'b0);
    run(1'b0, 16'h0033, 16'h0000, 0, 1'b0);
    // R8: offset 0 of a region whose neighbour was already written
    run(1'b1, 16'h0000, 16'h7777, 45, 1'b0);
    run(1'b0, 16'h0000, 16'h0000, 0, 1'b0);
    run(1'b0, 16'h0005, 16'h0000, 0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule